// File: doc/BRIEF.md
# SPI Flash Wake-Up Sequencer

This block runs once after reset and returns an attached serial flash to plain single-bit SPI, whatever wide mode a previous run left it in. It issues three all-ones preambles in separate chip-select frames: a 2-clock frame, so a part stuck in nibble-wide mode sees one all-ones byte with its upper data lines held high by board pull-ups; then an 8-clock frame that leaves quad mode; then a 16-clock frame that leaves dual mode. After that the bus is treated as single-bit SPI, mode 0.

The sequencer then polls the status register until the busy bit clears. This shows both that a device answers and that it is idle. When `reset_en` is set it sends a soft-reset pair, waits for a timed interval, and polls again. Finally it reads the three identification bytes and flags the flash as present only when they are neither all zeros nor all ones. SCK is the system clock divided by a parameter, and the reset wait is counted in system clocks from a clocks-per-microsecond parameter.

Controller states: `W_PRE2` (launches the 2-clock frame after reset), `W_PRE8`, `W_PRE16`, `W_POLL`, `W_RSTEN`, `W_RSTGO`, `W_HOLD`, `W_REPOLL`, `W_IDREAD`, `W_FINISH`. Transitions: each preamble state moves to the next when its frame ends, and `W_PRE16` moves to `W_POLL`. `W_POLL` repeats while busy, goes to `W_FINISH` when the poll limit is used up, and otherwise goes to `W_RSTEN` (when `reset_en` is set) or to `W_IDREAD`. `W_RSTEN` moves to `W_RSTGO`, which moves to `W_HOLD`. `W_HOLD` moves to `W_REPOLL` when the timer expires. `W_REPOLL` behaves like `W_POLL` but always goes on to `W_IDREAD`. `W_IDREAD` moves to `W_FINISH`, which is terminal. The frame engine inside cycles through `E_IDLE`, `E_LOW`, `E_HIGH` and `E_GAP`.

Top module: `flash_wake_seq`

## Requirements
- R1: While reset is held, cs_n is 1, sck is 0, mosi_oe is 0, done is 0 and present is 0.
- R2: The first frame after reset has exactly 2 SCK rising edges, with mosi at 1 on each.
- R3: The second frame has exactly 8 rising edges and the third has exactly 16, with mosi at 1 on every edge. The order is 2, then 8, then 16.
- R4: Between frames, cs_n stays high for at least 2 SCK periods (4*HALF_DIV system clocks). mosi_oe is 0 whenever cs_n is 1.
- R5: SPI mode 0: sck is 0 whenever cs_n is 1. Data is shifted MSB first and sampled on the rising sck edge.
- R6: After the preambles, each busy poll is a 16-clock frame whose first byte is 05h. Bit 0 of the returned status byte (the last bit of the frame) equal to 1 means busy, and the poll is repeated.
- R7: After POLL_LIMIT consecutive busy reads, done rises with present 0 and no ID frame is sent.
- R8: With reset_en at 1, a not-busy poll is followed by an 8-clock frame carrying 66h and then one carrying 99h. cs_n then stays high for at least CLKS_PER_US*RESET_WAIT_US system clocks before another busy poll.
- R9: With reset_en at 0, no 66h or 99h frame is sent, and the not-busy poll is followed directly by the ID frame.
- R10: The ID frame has 32 clocks and a first byte of 9Fh. The 24 bits returned after the command appear on id, with the first received bit as id[23].
- R11: present is 1 only when the received id is neither 000000h nor FFFFFFh.
- R12: done stays 1 once set, and no further frame is started after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; the sequence starts when it is released |
| reset_en | input | 1 | Sends the soft-reset pair and the timed wait when 1 |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| mosi_oe | output | 1 | Drive enable for mosi; 0 releases the line |
| done | output | 1 | Sequence finished |
| present | output | 1 | A flash with a plausible ID answered |
| id | output | 24 | Identification bytes from the last ID read |

## Verification
The hardest path to reach is the one where a device asserts busy across the soft reset and the re-poll must repeat after the timed wait. It is also hard to reach the poll limit running out, which is impractical with the default limit. The bench builds the block with a small poll limit and a short microsecond count, and attaches a behavioural flash model whose busy count and ID are set per scenario. A stuck-busy model then exhausts the limit in a few hundred cycles. Frame lengths, command bytes and chip-select gaps are recorded at the pins, so the order of the preambles and the length of the wait are checked from the bus itself.

// File: rtl/flash_wake_pkg.sv
package flash_wake_pkg;

    localparam int unsigned ID_W    = 24;
    localparam int unsigned FRAME_W = 8 + ID_W;
    localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_RST_EN = 8'h66;
    localparam logic [7:0] OP_RST_GO = 8'h99;
    localparam logic [7:0] OP_IDENT  = 8'h9F;

    typedef enum logic [3:0] {
        W_PRE2, W_PRE8, W_PRE16, W_POLL, W_RSTEN,
        W_RSTGO, W_HOLD, W_REPOLL, W_IDREAD, W_FINISH
    } wake_state_e;

    typedef enum logic [1:0] {
        E_IDLE, E_LOW, E_HIGH, E_GAP
    } eng_state_e;

    typedef struct packed {
        logic [LEN_W-1:0]   len;
        logic [FRAME_W-1:0] bits;
    } frame_t;

endpackage

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import flash_wake_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned GAP_SCK  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  frame_t             frame,
    input  logic               miso,
    output logic               sck,
    output logic               cs_n,
    output logic               mosi,
    output logic               mosi_oe,
    output logic [FRAME_W-1:0] rx,
    output logic               fin
);

    localparam int unsigned GAP_CLKS = GAP_SCK * 2 * HALF_DIV;
    localparam int unsigned TW       = $clog2(GAP_CLKS + 1);

    eng_state_e         st, st_nx;
    logic [TW-1:0]      tmr;
    logic [LEN_W-1:0]   left;
    logic [FRAME_W-1:0] sh;
    logic               hit;

    assign hit  = (tmr == '0);
    assign mosi = sh[FRAME_W-1];

    always_comb begin
        st_nx = st;
        unique case (st)
            E_IDLE: if (start) st_nx = E_LOW;
            E_LOW:  if (hit)   st_nx = E_HIGH;
            E_HIGH: if (hit)   st_nx = (left == LEN_W'(1)) ? E_GAP : E_LOW;
            E_GAP:  if (hit)   st_nx = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= E_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr     <= '0;
            left    <= '0;
            sh      <= '0;
            rx      <= '0;
            sck     <= 1'b0;
            cs_n    <= 1'b1;
            mosi_oe <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!hit) tmr <= tmr - TW'(1);
            unique case (st)
                E_IDLE: begin
                    if (start) begin
                        cs_n    <= 1'b0;
                        mosi_oe <= 1'b1;
                        sh      <= frame.bits;
                        left    <= frame.len;
                        tmr     <= TW'(HALF_DIV - 1);
                    end
                end
                E_LOW: begin
                    if (hit) begin
                        sck <= 1'b1;
                        rx  <= {rx[FRAME_W-2:0], miso};
                        tmr <= TW'(HALF_DIV - 1);
                    end
                end
                E_HIGH: begin
                    if (hit) begin
                        sck  <= 1'b0;
                        left <= left - LEN_W'(1);
                        if (left == LEN_W'(1)) begin
                            cs_n    <= 1'b1;
                            mosi_oe <= 1'b0;
                            tmr     <= TW'(GAP_CLKS - 1);
                        end else begin
                            sh  <= {sh[FRAME_W-2:0], 1'b0};
                            tmr <= TW'(HALF_DIV - 1);
                        end
                    end
                end
                E_GAP: begin
                    if (hit) fin <= 1'b1;
                end
            endcase
        end
    end

    // R5: clock idles low outside a frame
    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R4: data line released whenever chip select is high
    assert_oe_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !mosi_oe);

    // R3: a frame is only launched on an idle engine
    assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st == E_IDLE));

endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
    parameter int unsigned WAIT_CLKS = 10250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int unsigned CW = $clog2(WAIT_CLKS + 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (load)     cnt <= CW'(WAIT_CLKS);
        else if (!expired) cnt <= cnt - CW'(1);
    end

    // R8: a running count moves down by exactly one per cycle
    assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!expired && !load) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
    import flash_wake_pkg::*;
#(
    parameter int unsigned POLL_LIMIT = 65535
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_en,
    input  logic               fin,
    input  logic [FRAME_W-1:0] rx,
    input  logic               tmr_done,
    output logic               start,
    output frame_t             frame,
    output logic               tmr_load,
    output logic               done,
    output logic               present,
    output logic [ID_W-1:0]    id
);

    localparam int unsigned PW = $clog2(POLL_LIMIT + 1);

    wake_state_e   st, st_nx;
    logic          launch;
    logic          kicked;
    logic [PW-1:0] poll_cnt;
    logic          poll_last;
    logic          busy_bit;
    logic          polling;

    assign poll_last = (poll_cnt == PW'(POLL_LIMIT - 1));
    assign busy_bit  = rx[0];
    assign polling   = (st == W_POLL) || (st == W_REPOLL);

    function automatic frame_t frame_for(wake_state_e s);
        frame_t f;
        f.bits = '0;
        f.len  = '0;
        case (s)
            W_PRE2:   begin f.len = LEN_W'(2);  f.bits = '1; end
            W_PRE8:   begin f.len = LEN_W'(8);  f.bits = '1; end
            W_PRE16:  begin f.len = LEN_W'(16); f.bits = '1; end
            W_POLL,
            W_REPOLL: begin f.len = LEN_W'(16); f.bits = {OP_STATUS, {ID_W{1'b0}}}; end
            W_RSTEN:  begin f.len = LEN_W'(8);  f.bits = {OP_RST_EN, {ID_W{1'b0}}}; end
            W_RSTGO:  begin f.len = LEN_W'(8);  f.bits = {OP_RST_GO, {ID_W{1'b0}}}; end
            W_IDREAD: begin f.len = LEN_W'(FRAME_W); f.bits = {OP_IDENT, {ID_W{1'b0}}}; end
            default:  begin f.len = '0; f.bits = '0; end
        endcase
        return f;
    endfunction

    always_comb begin
        st_nx    = st;
        launch   = 1'b0;
        tmr_load = 1'b0;
        unique case (st)
            W_PRE2: begin
                if (!kicked) launch = 1'b1;
                else if (fin) begin st_nx = W_PRE8; launch = 1'b1; end
            end
            W_PRE8:  if (fin) begin st_nx = W_PRE16; launch = 1'b1; end
            W_PRE16: if (fin) begin st_nx = W_POLL;  launch = 1'b1; end
            W_POLL, W_REPOLL: begin
                if (fin) begin
                    if (!busy_bit) begin
                        st_nx  = (st == W_POLL && reset_en) ? W_RSTEN : W_IDREAD;
                        launch = 1'b1;
                    end else if (poll_last) begin
                        st_nx = W_FINISH;
                    end else begin
                        launch = 1'b1;
                    end
                end
            end
            W_RSTEN: if (fin) begin st_nx = W_RSTGO; launch = 1'b1; end
            W_RSTGO: if (fin) begin st_nx = W_HOLD; tmr_load = 1'b1; end
            W_HOLD:  if (tmr_done) begin st_nx = W_REPOLL; launch = 1'b1; end
            W_IDREAD: if (fin) st_nx = W_FINISH;
            W_FINISH: st_nx = W_FINISH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= W_PRE2;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kicked   <= 1'b0;
            start    <= 1'b0;
            frame    <= '0;
            poll_cnt <= '0;
            done     <= 1'b0;
            present  <= 1'b0;
            id       <= '0;
        end else begin
            kicked <= 1'b1;
            start  <= launch;
            if (launch) frame <= frame_for(st_nx);
            if ((st == W_PRE16 && fin) || (st == W_HOLD && tmr_done))
                poll_cnt <= '0;
            else if (polling && fin && busy_bit && !poll_last)
                poll_cnt <= poll_cnt + PW'(1);
            if (st_nx == W_FINISH && st != W_FINISH) done <= 1'b1;
            if (st == W_IDREAD && fin) begin
                id      <= rx[ID_W-1:0];
                present <= (rx[ID_W-1:0] != '0) && (rx[ID_W-1:0] != '1);
            end
        end
    end

    // R12: completion is final
    assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R12: nothing is launched after completion
    assert_quiet_after_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !start);

    // R11: present only reported with a finished sequence
    assert_present_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        present |-> done);

    // R8: the bus stays idle during the reset wait
    assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_HOLD) |-> !start);

    // R7: the poll count never passes its limit
    assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(poll_cnt) < POLL_LIMIT);

endmodule

// File: rtl/flash_wake_seq.sv
module flash_wake_seq
    import flash_wake_pkg::*;
#(
    parameter int unsigned HALF_DIV      = 2,
    parameter int unsigned GAP_SCK       = 2,
    parameter int unsigned CLKS_PER_US   = 250,
    parameter int unsigned RESET_WAIT_US = 41,
    parameter int unsigned POLL_LIMIT    = 65535
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reset_en,
    input  logic        miso,
    output logic        sck,
    output logic        cs_n,
    output logic        mosi,
    output logic        mosi_oe,
    output logic        done,
    output logic        present,
    output logic [23:0] id
);

    localparam int unsigned WAIT_CLKS = CLKS_PER_US * RESET_WAIT_US;

    logic               start;
    frame_t             frame;
    logic               fin;
    logic [FRAME_W-1:0] rx;
    logic               tmr_load;
    logic               tmr_done;
    logic [ID_W-1:0]    id_q;

    assign id = id_q;

    wake_ctrl #(.POLL_LIMIT(POLL_LIMIT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reset_en (reset_en),
        .fin      (fin),
        .rx       (rx),
        .tmr_done (tmr_done),
        .start    (start),
        .frame    (frame),
        .tmr_load (tmr_load),
        .done     (done),
        .present  (present),
        .id       (id_q)
    );

    spi_frame_engine #(.HALF_DIV(HALF_DIV), .GAP_SCK(GAP_SCK)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .frame   (frame),
        .miso    (miso),
        .sck     (sck),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .mosi_oe (mosi_oe),
        .rx      (rx),
        .fin     (fin)
    );

    wake_timer #(.WAIT_CLKS(WAIT_CLKS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_done)
    );

endmodule

// File: tb/flash_wake_seq_tb.sv
`timescale 1ns/1ps
module flash_wake_seq_tb;

    localparam int HALF     = 2;
    localparam int PER_US   = 2;
    localparam int WAIT_US  = 41;
    localparam int LIMIT    = 6;
    localparam int MIN_GAP  = 4 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_en = 1'b0;
    logic miso = 1'b0;
    logic sck, cs_n, mosi, mosi_oe, done, present;
    logic [23:0] id;

    always #2 clk = ~clk;

    flash_wake_seq #(
        .HALF_DIV(HALF), .GAP_SCK(2), .CLKS_PER_US(PER_US),
        .RESET_WAIT_US(WAIT_US), .POLL_LIMIT(LIMIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .reset_en(reset_en), .miso(miso),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .mosi_oe(mosi_oe),
        .done(done), .present(present), .id(id)
    );

    int checks = 0;
    int fails = 0;
    longint cyc = 0;
    bit finished = 0;

    // flash model state
    bit          dev_on;
    logic        flt;
    int          busy_left;
    logic [23:0] id_val;
    int          bitcnt;
    logic [7:0]  cmd;
    bit          ones;
    int          fr_n;
    int          fr_clk [64];
    logic [7:0]  fr_cmd [64];
    bit          fr_ones [64];
    longint      fr_fall [64];
    longint      fr_rise [64];
    int          oe_bad, sck_bad;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (rst_n) begin
        if (cs_n && mosi_oe) oe_bad++;
        if (cs_n && sck) sck_bad++;
    end

    always @(negedge cs_n) if (rst_n) begin
        bitcnt = 0; cmd = 8'h00; ones = 1;
        miso = flt;
        if (fr_n < 64) fr_fall[fr_n] = cyc;
    end

    always @(posedge sck) if (!cs_n) begin
        if (bitcnt < 8) cmd = {cmd[6:0], mosi};
        if (mosi !== 1'b1) ones = 0;
        bitcnt++;
    end

    always @(negedge sck) if (!cs_n) begin
        int k;
        k = bitcnt - 8;
        if (dev_on && bitcnt >= 8) begin
            if (cmd == 8'h05)                 miso = (k == 7) ? (busy_left > 0) : 1'b0;
            else if (cmd == 8'h9F && k < 24)  miso = id_val[23 - k];
            else                              miso = flt;
        end else begin
            miso = flt;
        end
    end

    always @(posedge cs_n) if (rst_n) begin
        if (fr_n < 64) begin
            fr_clk[fr_n]  = bitcnt;
            fr_cmd[fr_n]  = cmd;
            fr_ones[fr_n] = ones;
            fr_rise[fr_n] = cyc;
        end
        if (dev_on && cmd == 8'h05 && bitcnt == 16 && busy_left > 0) busy_left--;
        fr_n++;
        miso = flt;
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(bit ren, int busy, logic [23:0] idv, bit on, logic fl);
        rst_n = 1'b0;
        reset_en = ren; busy_left = busy; id_val = idv; dev_on = on; flt = fl;
        fr_n = 0; oe_bad = 0; sck_bad = 0; miso = fl;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        check(done === 1'b1, "R12", "done reached", done, 1);
    endtask

    function automatic int min_gap();
        int g = 1000000;
        for (int i = 0; i + 1 < fr_n && i + 1 < 64; i++)
            if (fr_fall[i+1] - fr_rise[i] < g) g = int'(fr_fall[i+1] - fr_rise[i]);
        return g;
    endfunction

    task automatic check_preambles();
        check(fr_clk[0] == 2 && fr_ones[0], "R2", "first frame 2 ones", fr_clk[0], 2);
        check(fr_clk[1] == 8 && fr_ones[1], "R3", "second frame 8 ones", fr_clk[1], 8);
        check(fr_clk[2] == 16 && fr_ones[2], "R3", "third frame 16 ones", fr_clk[2], 16);
    endtask

    task automatic test_reset_state();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cs_n === 1'b1 && sck === 1'b0 && mosi_oe === 1'b0, "R1",
              "bus idle in reset", {cs_n, sck, mosi_oe}, 3'b100);
        check(done === 1'b0 && present === 1'b0, "R1", "flags low in reset",
              {done, present}, 0);
    endtask

    task automatic test_plain_boot();
        run(0, 0, 24'hEF4018, 1, 1'b1);
        check_preambles();
        check(fr_n == 5, "R9", "frame count without reset pair", fr_n, 5);
        check(fr_cmd[3] == 8'h05 && fr_clk[3] == 16, "R6", "status poll frame", fr_cmd[3], 8'h05);
        check(fr_cmd[4] == 8'h9F && fr_clk[4] == 32, "R10", "id frame", fr_cmd[4], 8'h9F);
        check(id === 24'hEF4018, "R10", "id value", id, 24'hEF4018);
        check(present === 1'b1, "R11", "present for valid id", present, 1);
        check(min_gap() >= MIN_GAP, "R4", "chip-select gap", min_gap(), MIN_GAP);
        check(oe_bad == 0, "R4", "oe with cs high", oe_bad, 0);
        check(sck_bad == 0, "R5", "sck high with cs high", sck_bad, 0);
    endtask

    task automatic test_reset_pair();
        run(1, 3, 24'hC22017, 1, 1'b1);
        check_preambles();
        check(fr_n == 11, "R6", "frame count with 3 busy polls", fr_n, 11);
        check(fr_cmd[6] == 8'h05 && fr_cmd[7] == 8'h66 && fr_clk[7] == 8, "R8",
              "66h after last poll", fr_cmd[7], 8'h66);
        check(fr_cmd[8] == 8'h99 && fr_clk[8] == 8, "R8", "99h follows", fr_cmd[8], 8'h99);
        check(fr_cmd[9] == 8'h05, "R8", "poll after wait", fr_cmd[9], 8'h05);
        check(fr_fall[9] - fr_rise[8] >= PER_US * WAIT_US, "R8", "reset wait length",
              fr_fall[9] - fr_rise[8], PER_US * WAIT_US);
        check(fr_cmd[10] == 8'h9F && id === 24'hC22017 && present === 1'b1, "R10",
              "id after reset", id, 24'hC22017);
    endtask

    task automatic test_id_ones();
        run(0, 0, 24'hFFFFFF, 1, 1'b1);
        check(id === 24'hFFFFFF, "R10", "all-ones id read", id, 24'hFFFFFF);
        check(present === 1'b0, "R11", "absent for FFFFFF", present, 0);
    endtask

    task automatic test_id_zero();
        run(0, 0, 24'h000000, 0, 1'b0);
        check(fr_n == 5 && fr_cmd[4] == 8'h9F, "R9", "empty bus reaches id read", fr_n, 5);
        check(present === 1'b0 && id === 24'h0, "R11", "absent for 000000", present, 0);
    endtask

    task automatic test_stuck_busy();
        int n0;
        run(0, 1000000, 24'h123456, 1, 1'b1);
        check(fr_n == 3 + LIMIT, "R7", "poll count at limit", fr_n, 3 + LIMIT);
        check(fr_cmd[fr_n-1] == 8'h05, "R7", "no id frame after timeout", fr_cmd[fr_n-1], 8'h05);
        check(present === 1'b0, "R7", "absent after timeout", present, 0);
        n0 = fr_n;
        repeat (400) @(negedge clk);
        check(fr_n == n0 && cs_n === 1'b1, "R12", "bus quiet after done", fr_n, n0);
        check(done === 1'b1, "R12", "done held", done, 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        test_reset_state();
        test_plain_boot();
        test_reset_pair();
        test_id_ones();
        test_id_zero();
        test_stuck_busy();
        finish_run();
    end

endmodule